// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer. It runs on the fast input clock and emits one pulse to the phase detector every N input cycles, where N = P·B + A. P is the lower modulus of a dual-modulus prescaler and can be set to 8, 16, 32 or 64. The prescaler is a synchronous divide-by-4/5 stage followed by a group counter. It divides by P+1 while the swallow count A has not yet run out, and by P for the rest of the period. The main count B sets how many prescaler cycles make up one output period.

Software sets the modulus select, the swallow value and the main value, then strobes a load. The new setting is staged and only takes effect at the next period boundary, so no period ever has a length between the old and new ratios. The modulus-control line is brought out so that the swallow phase of each period can be seen.

Top module: `pulse_swallow_div`

## Requirements
- R1: With modulus select codes 0, 1, 2 and 3 giving P = 8, 16, 32 and 64, the number of input cycles from one rising edge of the output pulse to the next equals P·B + A, for B up to 8191 and A up to 63.
- R2: The output pulse is high for exactly one input-clock cycle in each period.
- R3: In each period, the modulus-control output is high for the first A·(P+1) input cycles and low for the remaining cycles.
- R4: A main value of 0, 1 or 2 on the load strobe is treated as 3.
- R5: A load strobe given in the middle of a period does not change that period's length. The loaded values apply from the following period onward.
- R6: While reset is held, the pulse and modulus-control outputs are low. After reset the divider runs with P = 8, B = 3, A = 0, so the first pulse comes 24 cycles after reset is released.
- R7: Each prescaler cycle lasts P+1 input cycles while modulus control is high, and P input cycles while it is low.
- R8: A = B is legal and gives a period of B·(P+1). Loading an A larger than the effective B is flagged as a programming error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_sel | input | 2 | Prescaler modulus select (0:8, 1:16, 2:32, 3:64) |
| swallow_val | input | 6 | Swallow count A |
| main_val | input | 13 | Main count B (values below 3 are raised to 3) |
| load | input | 1 | One-cycle strobe that stages mod_sel, swallow_val and main_val |
| div_pulse | output | 1 | One-cycle pulse per N input cycles, sent to the phase detector |
| mod_ctrl | output | 1 | High while the prescaler divides by P+1 |

## Verification
A fault in the 4/5 core or in the group counter changes the length of a prescaler cycle. This shows up as a wrong pulse interval in the very first period after the fault, off by a whole multiple of one cycle or of P. A swallow counter that fails to reach zero or reloads wrongly shows up in the count of modulus-control cycles within a single period. Wrong staging of a load shows up as a wrong length in the period that contains the strobe, or in the one right after it. The sweep covers every modulus with small B and A at both ends of their range, the clamped B values, and one run at the largest B, so each of these faults is exposed within two periods of the affected setting.

// File: rtl/psd_pkg.sv
package psd_pkg;
   typedef enum logic [1:0] {PS_8 = 2'd0, PS_16 = 2'd1, PS_32 = 2'd2, PS_64 = 2'd3} psel_e;

   localparam int unsigned CORE_BASE = 4;

   function automatic int unsigned low_modulus(input psel_e s);
      return 32'd8 << s;
   endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
   import psd_pkg::*;
#(
   parameter int unsigned GRP_W = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  psel_e psel,
   input  logic  mc,
   output logic  tick
);
   localparam int unsigned CORE_W = 3;
   localparam int unsigned CYC_W  = 7;

   if (GRP_W < 4) begin : g_bad_grp
      $error("GRP_W must be at least 4 to reach the 64/65 modulus");
   end

   logic [CORE_W-1:0] core_q;
   logic [GRP_W-1:0]  grp_q;
   logic [GRP_W-1:0]  grp_last;
   logic              last_grp, core_wrap;
   logic [CORE_W-1:0] core_term;

   always_comb begin
      case (psel)
         PS_8:    grp_last = GRP_W'(1);
         PS_16:   grp_last = GRP_W'(3);
         PS_32:   grp_last = GRP_W'(7);
         default: grp_last = GRP_W'(15);
      endcase
   end

   assign last_grp  = (grp_q == grp_last);
   assign core_term = (last_grp && mc) ? CORE_W'(CORE_BASE) : CORE_W'(CORE_BASE - 1);
   assign core_wrap = (core_q == core_term);
   assign tick      = core_wrap && last_grp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         core_q <= '0;
         grp_q  <= '0;
      end else if (core_wrap) begin
         core_q <= '0;
         grp_q  <= last_grp ? '0 : grp_q + 1'b1;
      end else begin
         core_q <= core_q + 1'b1;
      end
   end

   logic [CYC_W-1:0] cyc_q;
   always_ff @(posedge clk) begin
      if (!rst_n)    cyc_q <= '0;
      else if (tick) cyc_q <= '0;
      else           cyc_q <= cyc_q + 1'b1;
   end

   // R7
   presc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (32'(cyc_q) + 1 == low_modulus(psel) + (mc ? 32'd1 : 32'd0)));

   // R7
   core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_q <= CORE_W'(CORE_BASE));
endmodule

// File: rtl/psd_counters.sv
module psd_counters #(
   parameter int unsigned A_W   = 6,
   parameter int unsigned B_W   = 13,
   parameter int unsigned RST_A = 0,
   parameter int unsigned RST_B = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [A_W-1:0] a_init,
   input  logic [B_W-1:0] b_init,
   output logic           terminal,
   output logic           mc
);
   logic [A_W-1:0] a_q;
   logic [B_W-1:0] b_q;

   assign terminal = tick && (b_q == B_W'(1));
   assign mc       = (a_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= A_W'(RST_A);
         b_q <= B_W'(RST_B);
      end else if (tick) begin
         if (b_q == B_W'(1)) begin
            a_q <= a_init;
            b_q <= b_init;
         end else begin
            b_q <= b_q - 1'b1;
            if (a_q != '0) a_q <= a_q - 1'b1;
         end
      end
   end

   // R1
   main_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_q != '0);

   // R3
   swallow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mc && !terminal) |=> !mc);
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
   import psd_pkg::*;
#(
   parameter int unsigned A_W       = 6,
   parameter int unsigned B_W       = 13,
   parameter int unsigned B_MIN     = 3,
   parameter int unsigned RST_SEL   = 0,
   parameter int unsigned RST_A     = 0,
   parameter int unsigned RST_B     = 3,
   parameter bit          REG_PULSE = 1'b1
) (
   input  logic           clk_fast,
   input  logic           rst_n,
   input  logic [1:0]     mod_sel,
   input  logic [A_W-1:0] swallow_val,
   input  logic [B_W-1:0] main_val,
   input  logic           load,
   output logic           div_pulse,
   output logic           mod_ctrl
);
   localparam int unsigned GRP_W = 4;
   localparam int unsigned PER_W = B_W + 7;

   if (B_MIN < 1 || RST_B < B_MIN) begin : g_bad_min
      $error("B_MIN must be nonzero and RST_B must not be below it");
   end
   if (RST_A > RST_B) begin : g_bad_rst
      $error("reset swallow value exceeds reset main value");
   end

   logic [B_W-1:0] b_clamped;
   assign b_clamped = (main_val < B_W'(B_MIN)) ? B_W'(B_MIN) : main_val;

   psel_e          pend_sel, act_sel, src_sel;
   logic [A_W-1:0] pend_a, act_a, src_a;
   logic [B_W-1:0] pend_b, act_b, src_b;
   logic           tick, terminal;

   assign src_sel = load ? psel_e'(mod_sel) : pend_sel;
   assign src_a   = load ? swallow_val : pend_a;
   assign src_b   = load ? b_clamped : pend_b;

   always_ff @(posedge clk_fast) begin
      if (!rst_n) begin
         pend_sel <= psel_e'(RST_SEL);
         pend_a   <= A_W'(RST_A);
         pend_b   <= B_W'(RST_B);
         act_sel  <= psel_e'(RST_SEL);
         act_a    <= A_W'(RST_A);
         act_b    <= B_W'(RST_B);
      end else begin
         if (load) begin
            pend_sel <= psel_e'(mod_sel);
            pend_a   <= swallow_val;
            pend_b   <= b_clamped;
         end
         if (terminal) begin
            act_sel <= src_sel;
            act_a   <= src_a;
            act_b   <= src_b;
         end
      end
   end

   psd_prescaler #(.GRP_W(GRP_W)) u_presc (
      .clk  (clk_fast),
      .rst_n(rst_n),
      .psel (act_sel),
      .mc   (mod_ctrl),
      .tick (tick)
   );

   psd_counters #(.A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B)) u_cnt (
      .clk     (clk_fast),
      .rst_n   (rst_n),
      .tick    (tick),
      .a_init  (src_a),
      .b_init  (src_b),
      .terminal(terminal),
      .mc      (mod_ctrl)
   );

   if (REG_PULSE) begin : g_reg_pulse
      logic pulse_q;
      always_ff @(posedge clk_fast) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= terminal;
      end
      assign div_pulse = pulse_q;
   end else begin : g_comb_pulse
      assign div_pulse = terminal;
   end

   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] n_act;
   assign n_act = PER_W'(act_b) * (PER_W'(8) << act_sel) + PER_W'(act_a);

   always_ff @(posedge clk_fast) begin
      if (!rst_n)        per_q <= '0;
      else if (terminal) per_q <= '0;
      else               per_q <= per_q + 1'b1;
   end

   // R1
   period_len_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      terminal |-> (per_q + 1'b1 == n_act));

   // R2
   pulse_width_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   // R8
   ab_order_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      load |-> (B_W'(swallow_val) <= b_clamped));

   // R5
   stage_hold_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !$past(terminal) |-> $stable(act_b));
endmodule

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
   logic        clk_fast = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mod_sel = 2'd0;
   logic [5:0]  swallow_val = '0;
   logic [12:0] main_val = '0;
   logic        load = 1'b0;
   logic        div_pulse, mod_ctrl;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk_fast = ~clk_fast;

   pulse_swallow_div u0 (
      .clk_fast   (clk_fast),
      .rst_n      (rst_n),
      .mod_sel    (mod_sel),
      .swallow_val(swallow_val),
      .main_val   (main_val),
      .load       (load),
      .div_pulse  (div_pulse),
      .mod_ctrl   (mod_ctrl)
   );

   task automatic check(input string req, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // Starts on a sample that saw the pulse; returns at the sample of the next pulse.
   task automatic measure(input bit do_load, input int s, input int a, input int b,
                          output int len, output int mc_hi, output int wide);
      mc_hi = mod_ctrl ? 1 : 0;
      len = 0;
      wide = 0;
      forever begin
         @(negedge clk_fast);
         len++;
         if (len == 1 && div_pulse) wide = 1;
         if (do_load && len == 3) begin
            mod_sel = 2'(s);
            swallow_val = 6'(a);
            main_val = 13'(b);
            load = 1'b1;
         end
         if (len == 4) load = 1'b0;
         if (div_pulse && len > 1) break;
         if (len > 1) mc_hi += mod_ctrl ? 1 : 0;
         else if (!div_pulse) mc_hi += mod_ctrl ? 1 : 0;
         if (len > 600000) break;
      end
   endtask

   int old_n = 24;

   task automatic run_cfg(input int s, input int a, input int b, input string tag);
      int len, mc_hi, wide, p, be, n_new;
      p = 8 << s;
      be = (b < 3) ? 3 : b;
      n_new = be * p + a;
      measure(1'b1, s, a, b, len, mc_hi, wide);
      // R5: the period holding the load keeps its old length
      check("R5", len, old_n);
      measure(1'b0, 0, 0, 0, len, mc_hi, wide);
      check({"R1", tag}, len, n_new);
      // R3 / R7: swallow phase length
      check("R3 R7", mc_hi, a * (p + 1));
      // R2
      check("R2", wide, 0);
      old_n = n_new;
   endtask

   initial begin
      int cnt;
      repeat (3) begin
         @(negedge clk_fast);
         // R6: outputs low in reset
         check("R6", {31'd0, div_pulse}, 0);
         check("R6", {31'd0, mod_ctrl}, 0);
      end
      rst_n = 1'b1;
      cnt = 0;
      do begin
         @(negedge clk_fast);
         cnt++;
      end while (!div_pulse && cnt < 1000);
      // R6: default ratio 8*3+0
      check("R6", cnt, 24);

      for (int s = 0; s < 4; s++) begin
         for (int bi = 0; bi < 3; bi++) begin
            int b;
            b = (bi == 0) ? 3 : (bi == 1) ? 5 : 9;
            run_cfg(s, 0, b, "");
            run_cfg(s, 1, b, "");
            // R8: A equal to B
            run_cfg(s, b, b, " R8");
         end
      end
      // R4: clamped main values
      run_cfg(1, 2, 0, " R4");
      run_cfg(0, 3, 1, " R4");
      run_cfg(2, 0, 2, " R4");
      // R1: largest main and swallow values
      run_cfg(0, 63, 8191, " max");
      done = 1'b1;
   end

   initial begin
      int waited = 0;
      while (!done && waited < 190000) begin
         @(posedge clk_fast);
         waited++;
      end
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL watchdog: got %0d expected completion", waited);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule